// File: doc/BRIEF.md
# Multichannel PCM Timeslot Strobe Generator

This block divides a 2048 kHz bit clock into a repeating 125 µs frame. The frame holds 32 timeslots of eight bits each, so one frame lasts 256 bit clocks. A single shared chain of a bit counter and a timeslot counter runs the whole frame. A decoder turns that counter state into 30 separate frame-sync strobes, one for each voice codec. Each strobe repeats at 8 kHz.

A codec starts shifting its 8-bit PCM word on the rising edge of its strobe. Each strobe is therefore a short-frame pulse, one bit clock wide, placed in the bit period just before the first data bit of that codec's timeslot. Timeslot 0 carries frame alignment and timeslot 16 carries signalling, so neither has a codec strobe. Voice channels 1 to 15 use timeslots 1 to 15, and channels 16 to 30 use timeslots 17 to 31.

The block also outputs the current timeslot number and bit index, plus pulses that mark the first and last bit of the frame. A trunk multiplexer uses these to merge the codec bits into one serial stream. Reset is synchronous and active high.

Top module: `pcm_strobe_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block returns to timeslot 0, bit 0, and all bits of `codec_fs` go low. Once reset is released, that state is visible for one full clock.
- R2: `bit_idx` counts 0 to 7 and then wraps to 0. `slot_idx` advances by one on every wrap of `bit_idx` and goes from 31 back to 0.
- R3: `frame_start` is high exactly when `slot_idx` is 0 and `bit_idx` is 0, which is once every 256 clocks.
- R4: `frame_end` is high exactly when `slot_idx` is 31 and `bit_idx` is 7.
- R5: Bit k of `codec_fs` belongs to voice channel k+1. Channel c uses timeslot c when c ≤ 15 and timeslot c+1 when c ≥ 16. The strobe of a channel using timeslot t is high for exactly one clock per frame, in the cycle where `slot_idx` is t-1 and `bit_idx` is 7.
- R6: No more than one bit of `codec_fs` is high in any cycle.
- R7: No strobe announces timeslot 0 or timeslot 16. All of `codec_fs` is low in slot 31 bit 7 and in slot 15 bit 7.
- R8: Each strobe repeats with a period of exactly 256 clocks.
- R9: All of `codec_fs` is low whenever `bit_idx` is not 7.
- R10: A reset applied in the middle of a frame cancels a strobe that was about to be raised. The frame then restarts from timeslot 0, bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2048 kHz bit clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_idx | output | 5 | Current timeslot number, 0 to 31 |
| bit_idx | output | 3 | Bit position inside the current timeslot, 0 to 7 |
| frame_start | output | 1 | High in bit 0 of timeslot 0 |
| frame_end | output | 1 | High in bit 7 of timeslot 31 |
| codec_fs | output | 30 | One frame-sync strobe per voice codec; bit k serves channel k+1 |

## Verification
The assertions check several properties on every cycle:
- the counter stepping and wrap;
- the frame markers lining up with the counters;
- no more than one strobe active at a time;
- strobes appearing only in bit 7;
- each strobe being a single-cycle pulse sitting one timeslot before its mapped slot.

Some behaviour can only be shown by the bench's scenarios. The bench confirms that each listed channel fires exactly once per frame at its computed position. It checks that the period is 256 clocks across two frames and that the alignment and signalling slots stay silent. It also checks that a reset arriving one clock before a pending strobe cancels that strobe and restarts the frame.

// File: rtl/pcm_strobe_pkg.sv
package pcm_strobe_pkg;

    localparam int unsigned DEF_SLOTS     = 32;
    localparam int unsigned DEF_BITS      = 8;
    localparam int unsigned DEF_VOICE_CH  = 30;
    localparam int unsigned DEF_SIG_SLOT  = 16;

    typedef struct packed {
        logic first;
        logic last;
    } frame_mark_t;

    // Voice channel (1-based) to timeslot; the signalling slot is skipped.
    function automatic int chan_slot(input int ch, input int sig_slot);
        return (ch < sig_slot) ? ch : ch + 1;
    endfunction

endpackage

// File: rtl/frame_pos_counter.sv
module frame_pos_counter
    import pcm_strobe_pkg::*;
#(
    parameter int unsigned SLOTS = DEF_SLOTS,
    parameter int unsigned BPS   = DEF_BITS,
    localparam int unsigned SW   = $clog2(SLOTS),
    localparam int unsigned BW   = $clog2(BPS)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [SW-1:0] slot_q,
    output logic [BW-1:0] bit_q,
    output frame_mark_t   mark
);

    localparam logic [SW-1:0] SLOT_LAST = SW'(SLOTS - 1);
    localparam logic [BW-1:0] BIT_LAST  = BW'(BPS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
            bit_q  <= '0;
        end else if (bit_q == BIT_LAST) begin
            bit_q  <= '0;
            slot_q <= (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
        end else begin
            bit_q  <= bit_q + 1'b1;
        end
    end

    always_comb begin
        mark.first = (slot_q == '0) && (bit_q == '0);
        mark.last  = (slot_q == SLOT_LAST) && (bit_q == BIT_LAST);
    end

endmodule

// File: rtl/slot_strobe_decoder.sv
module slot_strobe_decoder
    import pcm_strobe_pkg::*;
#(
    parameter int unsigned SLOTS    = DEF_SLOTS,
    parameter int unsigned BPS      = DEF_BITS,
    parameter int unsigned VOICE_CH = DEF_VOICE_CH,
    parameter int unsigned SIG_SLOT = DEF_SIG_SLOT,
    localparam int unsigned SW      = $clog2(SLOTS),
    localparam int unsigned BW      = $clog2(BPS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SW-1:0]       slot_q,
    input  logic [BW-1:0]       bit_q,
    output logic [VOICE_CH-1:0] fs_q
);

    // The strobe is registered: decode one bit early so the pulse lands in the last bit.
    localparam logic [BW-1:0] BIT_ARM = BW'(BPS - 2);

    logic [VOICE_CH-1:0] arm;

    for (genvar k = 0; k < VOICE_CH; k++) begin : g_chan
        localparam int TS = chan_slot(k + 1, SIG_SLOT);
        assign arm[k] = (slot_q == SW'(TS - 1)) && (bit_q == BIT_ARM);
    end

    always_ff @(posedge clk) begin
        if (rst) fs_q <= '0;
        else     fs_q <= arm;
    end

endmodule

// File: rtl/pcm_strobe_gen.sv
module pcm_strobe_gen
    import pcm_strobe_pkg::*;
#(
    parameter int unsigned SLOTS    = DEF_SLOTS,
    parameter int unsigned BPS      = DEF_BITS,
    parameter int unsigned VOICE_CH = DEF_VOICE_CH,
    parameter int unsigned SIG_SLOT = DEF_SIG_SLOT,
    localparam int unsigned SW      = $clog2(SLOTS),
    localparam int unsigned BW      = $clog2(BPS)
) (
    input  logic                clk,
    input  logic                rst,
    output logic [SW-1:0]       slot_idx,
    output logic [BW-1:0]       bit_idx,
    output logic                frame_start,
    output logic                frame_end,
    output logic [VOICE_CH-1:0] codec_fs
);

    frame_mark_t mark;

    frame_pos_counter #(.SLOTS(SLOTS), .BPS(BPS)) cnt_i (
        .clk    (clk),
        .rst    (rst),
        .slot_q (slot_idx),
        .bit_q  (bit_idx),
        .mark   (mark)
    );

    slot_strobe_decoder #(
        .SLOTS(SLOTS), .BPS(BPS), .VOICE_CH(VOICE_CH), .SIG_SLOT(SIG_SLOT)
    ) dec_i (
        .clk    (clk),
        .rst    (rst),
        .slot_q (slot_idx),
        .bit_q  (bit_idx),
        .fs_q   (codec_fs)
    );

    assign frame_start = mark.first;
    assign frame_end   = mark.last;

endmodule

// File: rtl/pcm_strobe_gen_chk.sv
module pcm_strobe_gen_chk
    import pcm_strobe_pkg::*;
#(
    parameter int unsigned SLOTS    = DEF_SLOTS,
    parameter int unsigned BPS      = DEF_BITS,
    parameter int unsigned VOICE_CH = DEF_VOICE_CH,
    parameter int unsigned SIG_SLOT = DEF_SIG_SLOT,
    localparam int unsigned SW      = $clog2(SLOTS),
    localparam int unsigned BW      = $clog2(BPS)
) (
    input logic                clk,
    input logic                rst,
    input logic [SW-1:0]       slot_idx,
    input logic [BW-1:0]       bit_idx,
    input logic                frame_start,
    input logic                frame_end,
    input logic [VOICE_CH-1:0] codec_fs
);

    localparam logic [BW-1:0] BL = BW'(BPS - 1);
    localparam logic [SW-1:0] SL = SW'(SLOTS - 1);

    a_r2_bit_step: assert property (@(posedge clk) disable iff (rst)
        (bit_idx != BL) |=> (bit_idx == $past(bit_idx) + 1'b1) && $stable(slot_idx));
    a_r2_bit_wrap: assert property (@(posedge clk) disable iff (rst)
        (bit_idx == BL) |=> (bit_idx == '0));
    a_r2_slot_step: assert property (@(posedge clk) disable iff (rst)
        (bit_idx == BL && slot_idx != SL) |=> (slot_idx == $past(slot_idx) + 1'b1));
    a_r2_slot_wrap: assert property (@(posedge clk) disable iff (rst)
        (bit_idx == BL && slot_idx == SL) |=> (slot_idx == '0));
    a_r3_frame_start: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (slot_idx == '0 && bit_idx == '0));
    a_r4_frame_end: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> frame_start);
    a_r6_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(codec_fs));
    a_r9_last_bit_only: assert property (@(posedge clk) disable iff (rst)
        (|codec_fs) |-> (bit_idx == BL));
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (|codec_fs) |=> (codec_fs == '0));
    a_r7_no_reserved: assert property (@(posedge clk) disable iff (rst)
        (bit_idx == BL && (slot_idx == SW'(SIG_SLOT - 1) || slot_idx == SL))
            |-> (codec_fs == '0));

    for (genvar k = 0; k < VOICE_CH; k++) begin : g_map
        localparam int TS = chan_slot(k + 1, SIG_SLOT);
        a_r5_slot_map: assert property (@(posedge clk) disable iff (rst)
            codec_fs[k] |-> (slot_idx == SW'(TS - 1)));
    end

endmodule

bind pcm_strobe_gen pcm_strobe_gen_chk #(
    .SLOTS(SLOTS), .BPS(BPS), .VOICE_CH(VOICE_CH), .SIG_SLOT(SIG_SLOT)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .slot_idx    (slot_idx),
    .bit_idx     (bit_idx),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .codec_fs    (codec_fs)
);

// File: tb/pcm_strobe_gen_tb_top.sv
`timescale 1ns/1ps
module pcm_strobe_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  slot_idx;
    logic [2:0]  bit_idx;
    logic        frame_start;
    logic        frame_end;
    logic [29:0] codec_fs;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pcm_strobe_gen dut_i (
        .clk(clk), .rst(rst), .slot_idx(slot_idx), .bit_idx(bit_idx),
        .frame_start(frame_start), .frame_end(frame_end), .codec_fs(codec_fs)
    );

    // {channel[4:0], expected timeslot[4:0]}
    localparam logic [9:0] VEC [8] = '{
        {5'd1, 5'd1},   {5'd2, 5'd2},   {5'd8, 5'd8},   {5'd15, 5'd15},
        {5'd16, 5'd17}, {5'd17, 5'd18}, {5'd29, 5'd30}, {5'd30, 5'd31}
    };

    task automatic check(input string req, input bit ok, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    int pos1 [30];
    int pos2 [30];
    int hits [30];
    int e_r2, e_r3, e_r4, e_r6, e_r7, e_r9;

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 30; k++) begin
            pos1[k] = -1; pos2[k] = -1; hits[k] = 0;
        end
        e_r2 = 0; e_r3 = 0; e_r4 = 0; e_r6 = 0; e_r7 = 0; e_r9 = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state visible right after release
        check("R1 slot", slot_idx == 0, slot_idx, 0);
        check("R1 bit", bit_idx == 0, bit_idx, 0);
        check("R1 strobes", codec_fs == 0, codec_fs, 0);

        // Two-frame sweep, sampling once per clock away from the edge
        for (int c = 0; c < 512; c++) begin
            int p;
            p = c % 256;
            if (slot_idx != p / 8 || bit_idx != p % 8) e_r2++;
            if (frame_start != (p == 0)) e_r3++;
            if (frame_end != (p == 255)) e_r4++;
            if ($countones(codec_fs) > 1) e_r6++;
            if ((p == 127 || p == 255) && codec_fs != 0) e_r7++;
            if (bit_idx != 7 && codec_fs != 0) e_r9++;
            for (int k = 0; k < 30; k++) begin
                if (codec_fs[k]) begin
                    hits[k]++;
                    if (c < 256) pos1[k] = c; else pos2[k] = c;
                end
            end
            @(negedge clk);
            #1;
        end
        check("R2 counter sequence errors", e_r2 == 0, e_r2, 0);
        check("R3 frame_start errors", e_r3 == 0, e_r3, 0);
        check("R4 frame_end errors", e_r4 == 0, e_r4, 0);
        check("R6 multi-strobe cycles", e_r6 == 0, e_r6, 0);
        check("R7 reserved-slot strobes", e_r7 == 0, e_r7, 0);
        check("R9 strobes off bit 7", e_r9 == 0, e_r9, 0);

        // R5: table of channel to timeslot mapping
        for (int v = 0; v < 8; v++) begin
            int ch, ts;
            ch = int'(VEC[v][9:5]);
            ts = int'(VEC[v][4:0]);
            check($sformatf("R5 ch%0d position", ch), pos1[ch-1] == ts * 8 - 1, pos1[ch-1], ts * 8 - 1);
            check($sformatf("R5 ch%0d pulses in 2 frames", ch), hits[ch-1] == 2, hits[ch-1], 2);
        end

        // R8: every strobe recurs after exactly 256 clocks
        for (int k = 0; k < 30; k++)
            check($sformatf("R8 ch%0d period", k + 1), pos2[k] - pos1[k] == 256, pos2[k] - pos1[k], 256);

        // R10: reset one clock before channel 5's strobe would rise
        while (!(slot_idx == 4 && bit_idx == 6)) begin
            @(negedge clk);
            #1;
        end
        rst = 1'b1;
        @(negedge clk);
        #1;
        check("R10 pending strobe cancelled", codec_fs == 0, codec_fs, 0);
        rst = 1'b0;
        #0.1;
        check("R10 restart slot", slot_idx == 0, slot_idx, 0);
        check("R10 restart bit", bit_idx == 0, bit_idx, 0);
        repeat (7) @(negedge clk);
        #1;
        check("R10 ch1 strobe after restart", codec_fs == 30'd1, codec_fs, 1);
        check("R3 no frame_start mid-slot", frame_start == 0, frame_start, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule